// File: doc/BRIEF.md
# Frame-locked fractional bit-clock divider

This block turns a parallel-port byte clock into a 4.096 MHz serial bit clock. Two input rates can be used. With the 16.384 MHz byte clock the output is a plain divide-by-4. With the 19.44 MHz byte clock the ratio is not an integer. A 125 µs frame then spans 2430 input cycles, which are 4860 half-cycles, and it must still hold exactly 512 output cycles. The block steps a phase accumulator once per half-cycle of the input clock. It places each output transition on a rising or a falling input edge. The short and long output phases are spread evenly across the frame.

The divided clock is locked to the parallel receive frame sync. Each sync pulse restarts the pattern, so the first output rising edge of a frame lines up with the frame start. Between sync pulses the divider free-runs on its accumulator. The divider only runs when the enable input is set and a supported rate is chosen. Otherwise its output stays low. The low-rate setting of the parallel port cannot use the divider and is refused.

Top module: `fdiv_frame_clkgen`

## Requirements
- R1: `rate_i` encodes the rate as follows: 0 selects the 16.384 MHz byte clock, 1 selects the 19.44 MHz byte clock, 2 is the 6.48 MB/s port rate and 3 is unused. With code 0 and enabled, `clk_o` is high for 2 input cycles and then low for 2. It starts high in the input cycle of a restart.
- R2: With enable set and frame syncs spaced 2048 input cycles apart (code 0) or 2430 input cycles apart (code 1), exactly 512 rising edges of `clk_o` occur from one sync to the next.
- R3: With code 1, number the half-cycles after a restart from n = 0, where n = 0 is the high phase of the input cycle whose rising edge saw the restart. `clk_o` is high in half-cycle n exactly when floor(1024·n / 4860) is even. So every high phase and every low phase lasts 4 or 5 input half-cycles.
- R4: With code 1, rising edges of `clk_o` fall on rising input edges at some times and on falling input edges at others.
- R5: From the second rising input edge after `en_i` goes low, `clk_o` stays low.
- R6: With code 2 or 3 the enable is ignored. From the second rising input edge on, `clk_o` stays low.
- R7: A high `fsync_i` sampled on a rising input edge restarts the pattern of R1 or R3 at n = 0 on that edge, whatever the phase was before.
- R8: Turning the enable on, or changing the rate code while enabled, restarts the pattern on the first rising edge that sees the new setting, in the same way a frame sync does.
- R9: Without frame syncs the pattern keeps running. The formula of R3 holds past 4860 half-cycles, so each 2430-cycle span still holds 512 output cycles.
- R10: While the synchronous reset `rst_i` is high, `clk_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Parallel-port byte clock; both edges are used |
| rst_i | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Divider enable |
| rate_i | input | 2 | Rate code: 0 = 16.384 MHz, 1 = 19.44 MHz, 2 = 6.48 MB/s, 3 = unused |
| fsync_i | input | 1 | Receive frame sync, one-cycle high pulse sampled on a rising edge |
| clk_o | output | 1 | Divided 4.096 MHz bit clock, low when not running |

## Verification
The output is sampled in every input half-cycle and compared with the floor formula, for both rate codes. Traces start from a frame sync, from an enable and from a rate change. Some traces run for two frames with no sync, which separates correct free-running wrap-around from a pattern that only looks right just after a restart. Rising edges are counted over several sync-to-sync spans at both frame lengths. Frame syncs are also placed at odd offsets in the middle of a frame, which shows whether a restart really discards the old phase. Random sequences of enable, rate code and sync timing are mixed in, and they include the refused codes, where the output must stay low.

// File: rtl/fdiv_pkg.sv
`timescale 1ns/1ps
package fdiv_pkg;

  // Rate code on the rate select input
  typedef enum logic [1:0] {
    RATE_B16 = 2'd0,
    RATE_B19 = 2'd1,
    RATE_B6  = 2'd2,
    RATE_RSV = 2'd3
  } rate_e;

  // Number of input half-cycles handled per rising edge
  localparam int SLOTS_PER_CYCLE = 2;

endpackage

// File: rtl/fdiv_frac_core.sv
`timescale 1ns/1ps
// Half-cycle phase accumulator for the non-integer ratio.
// Works out the output level for the high and the low phase of the current
// input cycle on each rising edge.
module fdiv_frac_core #(
  parameter int FRAME_HALVES = 4860,
  parameter int TOG_STEP     = 1024
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       run_i,
  input  logic       start_i,
  output logic [1:0] lvl_o
);
  import fdiv_pkg::*;

  localparam int ACC_W = $clog2(FRAME_HALVES + TOG_STEP);
  localparam logic [ACC_W-1:0] FRAME_A = ACC_W'(FRAME_HALVES);
  localparam logic [ACC_W-1:0] STEP_A  = ACC_W'(TOG_STEP);
  // Seed chosen so the very first half-cycle wraps, which gives a rising output
  localparam logic [ACC_W-1:0] SEED_A  = ACC_W'(FRAME_HALVES - TOG_STEP);

  logic [ACC_W-1:0] acc_q;
  logic             lvl_q;
  logic [ACC_W-1:0] acc_c [0:SLOTS_PER_CYCLE];
  logic             lvl_c [0:SLOTS_PER_CYCLE];

  assign acc_c[0] = start_i ? SEED_A : acc_q;
  assign lvl_c[0] = start_i ? 1'b0   : lvl_q;

  for (genvar s = 0; s < SLOTS_PER_CYCLE; s++) begin : g_slot
    logic [ACC_W-1:0] sum;
    logic             wrap;
    assign sum          = acc_c[s] + STEP_A;
    assign wrap         = (sum >= FRAME_A);
    assign acc_c[s+1]   = wrap ? (sum - FRAME_A) : sum;
    assign lvl_c[s+1]   = lvl_c[s] ^ wrap;
    assign lvl_o[s]     = lvl_c[s+1];
  end

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      acc_q <= SEED_A;
      lvl_q <= 1'b0;
    end else begin
      acc_q <= acc_c[SLOTS_PER_CYCLE];
      lvl_q <= lvl_c[SLOTS_PER_CYCLE];
    end
  end

  // R2: the stored phase never leaves one frame of half-cycles
  p_acc_bound_r2: assert property (@(posedge clk_i) disable iff (rst_i)
    acc_q < FRAME_A);

endmodule

// File: rtl/fdiv_int_core.sv
`timescale 1ns/1ps
// Integer divider: output level per input cycle, the same for both phases.
module fdiv_int_core #(
  parameter int INT_DIV = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       run_i,
  input  logic       start_i,
  output logic [1:0] lvl_o
);
  localparam int CNT_W = (INT_DIV > 2) ? $clog2(INT_DIV) : 1;
  localparam logic [CNT_W-1:0] HALF_C = CNT_W'(INT_DIV / 2);
  localparam logic [CNT_W-1:0] LAST_C = CNT_W'(INT_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] base;
  logic [CNT_W-1:0] cnt_nxt;
  logic             lvl;

  assign base = start_i ? '0 : cnt_q;
  assign lvl  = (base < HALF_C);

  if ((1 << CNT_W) == INT_DIV) begin : g_pow2
    assign cnt_nxt = base + 1'b1;
  end else begin : g_any
    assign cnt_nxt = (base == LAST_C) ? '0 : base + 1'b1;
  end

  assign lvl_o = {lvl, lvl};

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) cnt_q <= '0;
    else                 cnt_q <= cnt_nxt;
  end

  // R1: a restart puts the count at one step past the start of the period
  p_restart_count_r1: assert property (@(posedge clk_i) disable iff (rst_i)
    (run_i && start_i) |=> (cnt_q == CNT_W'(1)));

endmodule

// File: rtl/fdiv_edge_combiner.sv
`timescale 1ns/1ps
// Puts two half-cycle levels together into one glitch-free output.
// One flop on the rising edge and one on the falling edge are XORed.
module fdiv_edge_combiner (
  input  logic clk_i,
  input  logic rst_i,
  input  logic run_i,
  input  logic lvl_hi_i,
  input  logic lvl_lo_i,
  output logic clk_o
);
  logic tp_q;
  logic lo_q;
  logic tn_q;

  always_ff @(posedge clk_i) begin
    if (rst_i || !run_i) begin
      tp_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      tp_q <= lvl_hi_i ^ tn_q;
      lo_q <= lvl_lo_i;
    end
  end

  always_ff @(negedge clk_i) begin
    if (rst_i) tn_q <= 1'b0;
    else       tn_q <= tp_q ^ lo_q;
  end

  assign clk_o = tp_q ^ tn_q;

  // R3: the level for the low phase shows up in that phase
  p_low_slot_r3: assert property (@(posedge clk_i) disable iff (rst_i)
    run_i |=> (clk_o == $past(lvl_lo_i)));

endmodule

// File: rtl/fdiv_frame_clkgen.sv
`timescale 1ns/1ps
module fdiv_frame_clkgen #(
  parameter int FRAME_HALVES = 4860,
  parameter int OUT_CYCLES   = 512,
  parameter int INT_DIV      = 4
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       en_i,
  input  logic [1:0] rate_i,
  input  logic       fsync_i,
  output logic       clk_o
);
  import fdiv_pkg::*;

  localparam int TOG_STEP = 2 * OUT_CYCLES;

  rate_e      rate;
  rate_e      rate_q;
  logic       rate_ok;
  logic       run;
  logic       run_q;
  logic       start;
  logic [1:0] frac_lvl;
  logic [1:0] int_lvl;
  logic [1:0] lvl;

  assign rate    = rate_e'(rate_i);
  assign rate_ok = (rate == RATE_B16) || (rate == RATE_B19);
  assign run     = en_i && rate_ok;
  assign start   = run && (fsync_i || !run_q || (rate != rate_q));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      run_q  <= 1'b0;
      rate_q <= RATE_B16;
    end else begin
      run_q  <= run;
      rate_q <= rate;
    end
  end

  fdiv_frac_core #(
    .FRAME_HALVES(FRAME_HALVES),
    .TOG_STEP    (TOG_STEP)
  ) frac_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (run && (rate == RATE_B19)),
    .start_i(start),
    .lvl_o  (frac_lvl)
  );

  fdiv_int_core #(
    .INT_DIV(INT_DIV)
  ) int_i (
    .clk_i  (clk_i),
    .rst_i  (rst_i),
    .run_i  (run && (rate == RATE_B16)),
    .start_i(start),
    .lvl_o  (int_lvl)
  );

  assign lvl = (rate == RATE_B19) ? frac_lvl : int_lvl;

  fdiv_edge_combiner comb_i (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .run_i   (run),
    .lvl_hi_i(lvl[0]),
    .lvl_lo_i(lvl[1]),
    .clk_o   (clk_o)
  );

  // R5: a cleared enable gives a low output in the next low phase
  p_idle_low_r5: assert property (@(posedge clk_i) disable iff (rst_i)
    !en_i |=> !clk_o);

  // R6: a refused rate code gives a low output even when enabled
  p_bad_rate_r6: assert property (@(posedge clk_i) disable iff (rst_i)
    (en_i && !rate_ok) |=> !clk_o);

  // R7: after a restart the output is high through the first low phase
  p_frame_phase_r7: assert property (@(posedge clk_i) disable iff (rst_i)
    (run && fsync_i) |=> clk_o);

endmodule

// File: tb/fdiv_frame_clkgen_tb.sv
`timescale 1ns/1ps
module fdiv_frame_clkgen_tb_top;

  localparam int HALF_NS  = 10;
  localparam int FRAME_H  = 4860;
  localparam int TOG_N    = 1024;
  localparam int WD_CYC   = 150000;

  logic       clk = 1'b0;
  logic       rst;
  logic       en;
  logic [1:0] rate;
  logic       fs;
  logic       clk_o;

  int checks = 0;
  int fails  = 0;
  int rises  = 0;
  bit done   = 0;

  always #(HALF_NS) clk = ~clk;

  fdiv_frame_clkgen dut_i (
    .clk_i  (clk),
    .rst_i  (rst),
    .en_i   (en),
    .rate_i (rate),
    .fsync_i(fs),
    .clk_o  (clk_o)
  );

  always @(posedge clk_o) rises++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Expected level in half-cycle n after a restart
  function automatic bit model_level(input int r, input int n);
    if (r == 1) return ((TOG_N * n) / FRAME_H) % 2 == 0;
    return ((n / 4) % 2) == 0;
  endfunction

  // Called at edge+3; the sync is sampled on the next rising edge
  task automatic pulse_fs();
    fs = 1'b1;
    @(posedge clk);
    #3;
    fs = 1'b0;
  endtask

  // Called at restart edge + 3; samples every half-cycle
  task automatic trace(input int r, input int nslots, input string req);
    int mism = 0, first = -1, badrun = 0, rpos = 0, rneg = 0, runlen = 0;
    bit prev = 1'b0;
    bit v;
    for (int n = 0; n < nslots; n++) begin
      v = clk_o;
      if (v != model_level(r, n)) begin
        if (mism == 0) first = n;
        mism++;
      end
      if (n > 0 && v != prev) begin
        if (r == 1 && (runlen < 4 || runlen > 5)) badrun++;
        if (r == 0 && runlen != 4) badrun++;
        runlen = 1;
        if (v) begin
          if (n % 2 == 1) rneg++;
          else            rpos++;
        end
      end else begin
        runlen++;
      end
      prev = v;
      #(HALF_NS);
    end
    chk(mism == 0, req, $sformatf("half-cycle mismatches (first at %0d)", first), mism, 0);
    chk(badrun == 0, (r == 1) ? "R3" : "R1", "phase lengths out of range", badrun, 0);
    if (r == 1)
      chk(rneg > 0 && rpos > 0, "R4", "rises on falling input edges", rneg, 1);
  endtask

  // Counts output rises between frame syncs L cycles apart
  task automatic frame_count(input int len, input int nframes, input string req);
    int c0;
    pulse_fs();
    c0 = rises;
    for (int f = 0; f < nframes; f++) begin
      repeat (len - 1) @(posedge clk);
      #3;
      pulse_fs();
      chk(rises - c0 == 512, req, $sformatf("rises in frame %0d", f), rises - c0, 512);
      c0 = rises;
    end
  endtask

  // Called at edge+3 after a setting change; output must stay low
  task automatic idle_check(input string req);
    int hi = 0;
    repeat (2) @(posedge clk);
    #3;
    for (int n = 0; n < 40; n++) begin
      if (clk_o) hi++;
      #(HALF_NS);
    end
    chk(hi == 0, req, "high half-cycles while idle", hi, 0);
  endtask

  initial begin
    #(WD_CYC * 2 * HALF_NS);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int r, len, gap;
    bit e;
    void'($urandom(32'h00C0FFEE));
    rst = 1'b1; en = 1'b0; rate = 2'd0; fs = 1'b0;
    repeat (5) @(posedge clk);
    #3;
    chk(clk_o == 1'b0, "R10", "output in reset", clk_o, 0);
    en = 1'b1;
    @(posedge clk);
    #3;
    chk(clk_o == 1'b0, "R10", "output with reset held", clk_o, 0);
    rst = 1'b0;
    en = 1'b0;
    idle_check("R5");

    // Integer mode from a frame sync
    en = 1'b1; rate = 2'd0;
    pulse_fs();
    trace(0, 400, "R1");
    frame_count(2048, 3, "R2");

    // Rate change while enabled restarts the pattern
    rate = 2'd1;
    @(posedge clk);
    #3;
    trace(1, 200, "R8");

    // Two full frames with no sync in between
    pulse_fs();
    trace(1, 2 * FRAME_H, "R9");
    frame_count(2430, 3, "R2");

    // Sync in the middle of a frame at an odd offset
    repeat (777) @(posedge clk);
    #3;
    pulse_fs();
    trace(1, 600, "R7");
    repeat (101) @(posedge clk);
    #3;
    rate = 2'd0;
    repeat (3) @(posedge clk);
    #3;
    pulse_fs();
    trace(0, 120, "R7");

    // Enable off, and refused rate codes
    en = 1'b0;
    idle_check("R5");
    en = 1'b1; rate = 2'd2;
    idle_check("R6");
    rate = 2'd3;
    pulse_fs();
    idle_check("R6");

    // Enable back on: restart without a sync
    rate = 2'd1;
    @(posedge clk);
    #3;
    trace(1, 300, "R8");

    // Random settings, sync timing and trace lengths
    for (int it = 0; it < 10; it++) begin
      r   = $urandom_range(0, 3);
      e   = ($urandom_range(0, 3) != 0);
      gap = $urandom_range(1, 60);
      len = 2 * $urandom_range(60, 300);
      en = e; rate = r[1:0];
      repeat (gap) @(posedge clk);
      #3;
      if (e && r < 2) begin
        pulse_fs();
        trace(r, len, (r == 1) ? "R3" : "R1");
      end else begin
        idle_check(e ? "R6" : "R5");
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule